// File: doc/BRIEF.md
# I2C master bit timing generator

This block turns single bus-level commands into the SCL and SDA waveforms of an I2C master. All timing is counted in system clock cycles. A divider value sets how long SCL stays low and high. A six-bit frequency code selects how long SDA is held after SCL falls, and how long SCL is held after a start condition. The block issues only drive-low enables for the two open-drain lines. An external pull-up, or another device, decides when a released line actually goes high.

A controller above this block shifts bytes and handles acknowledge. It hands commands to this block over a valid/ready handshake: start, repeated start, one data bit, or stop. The block accepts a command only while it is idle. It plays the matching waveform and pulses done for one cycle when the waveform is finished. Timing parameters are latched when a command is accepted. After SCL is released, the high phase is not counted until the synchronised SCL input actually reads high, so a slave can stretch the clock.

Top module: `i2c_bit_timer`

## Requirements
- R1: During and right after reset, both drive-low outputs are 0, done is 0 and ready is 1.
- R2: START (op code 0) drives SDA low in the cycle after acceptance. It drives SCL low B cycles later and pulses done in that same cycle.
- R3: The start hold B is computed as follows. Take the divider shifted right by 4. While the value is not below the limit, halve it; the limit is 16 when code bit 5 is 0 and 9 when it is 1. If the result is 0, use 1.
- R4: The data hold D is 8 + (16 << code[4:2]) * k. Here k is 1, 2, 3 or 4 when {code[5],code[1]} is 10, 11, 00 or 01. D is clamped to H-1, where H = max(2, divider/2).
- R5: WRITE (op code 2) changes SDA to the bit value D cycles after acceptance, driving low for bit 0 and releasing for bit 1. It releases SCL H cycles after acceptance.
- R6: After SCL is released, the high phase starts once the SCL input, passed through SYNC_STAGES flops, reads high. This is SYNC_STAGES+1 cycles after the line goes high. For WRITE, SCL is driven low again H cycles into the high phase, with done pulsed in the same cycle.
- R7: RSTART (op code 1) releases SDA at D and SCL at H. It drives SDA low (divider + B) cycles into the high phase, then drives SCL low B cycles later with done.
- R8: STOP (op code 3) drives SDA low at D and releases SCL at H. It releases SDA 4 cycles into the high phase with done, leaving both lines released.
- R9: Ready is 0 from acceptance until the done cycle. A valid command presented while ready is 0 has no effect. Done is a one-cycle pulse.
- R10: Reset applied in the middle of a sequence returns the block to the R1 state.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high reset |
| div_i | input | DIV_W | Divider value in clocks per SCL period |
| fdr_i | input | 6 | Frequency code selecting hold times |
| cmd_valid_i | input | 1 | Command request |
| cmd_op_i | input | 2 | 0 start, 1 repeated start, 2 write bit, 3 stop |
| cmd_bit_i | input | 1 | Data bit for write |
| cmd_ready_o | output | 1 | Idle and able to accept a command |
| scl_i | input | 1 | Sampled level of the SCL line |
| scl_low_o | output | 1 | Drive SCL low when 1, release when 0 |
| sda_low_o | output | 1 | Drive SDA low when 1, release when 0 |
| done_o | output | 1 | One-cycle pulse when a sequence ends |

## Verification
The hardest case to reach is a slave holding SCL low after the master releases it. The waveform must then pause without losing count, and the synchroniser latency must still add exactly the same delay. The bench models the pull-up together with a slave that holds SCL low for a programmable number of cycles after each release, and sets a different stretch length per vector. Clamped hold values, a zero start-hold result, and a command presented while busy are also reached through chosen divider and code values and through an extra valid pulse mid-sequence.

// File: rtl/i2c_bt_pkg.sv
package i2c_bt_pkg;
  typedef enum logic [1:0] {
    OP_START  = 2'd0,
    OP_RSTART = 2'd1,
    OP_WRITE  = 2'd2,
    OP_STOP   = 2'd3
  } bt_op_e;

  typedef enum logic [2:0] {
    ST_IDLE,
    ST_SHOLD,
    ST_LOW,
    ST_RISE,
    ST_HIGH
  } bt_state_e;
endpackage

// File: rtl/i2c_bt_timing.sv
module i2c_bt_timing #(
  parameter int DIV_W = 12,
  parameter int CNT_W = 15
) (
  input  logic             clk,
  input  logic             rst,
  input  logic [DIV_W-1:0] div_i,
  input  logic [5:0]       fdr_i,
  output logic [CNT_W-1:0] half_o,
  output logic [CNT_W-1:0] hold_o,
  output logic [CNT_W-1:0] shold_o,
  output logic [CNT_W-1:0] setup_o
);
  logic [CNT_W-1:0] half_raw;
  logic [CNT_W-1:0] step;
  logic [CNT_W-1:0] hold_raw;
  logic [2:0]       mult;
  logic [DIV_W-1:0] q;
  logic [DIV_W-1:0] lim;

  // half period with a floor of two cycles
  always_comb begin
    half_raw = CNT_W'(div_i >> 1);
    half_o   = (half_raw < CNT_W'(2)) ? CNT_W'(2) : half_raw;
  end

  // data hold: scaled step times a multiplier picked by two code bits
  always_comb begin
    case ({fdr_i[5], fdr_i[1]})
      2'b10:   mult = 3'd1;
      2'b11:   mult = 3'd2;
      2'b00:   mult = 3'd3;
      default: mult = 3'd4;
    endcase
    step     = CNT_W'(16) << fdr_i[4:2];
    hold_raw = CNT_W'(8) + step * CNT_W'(mult);
    hold_o   = (hold_raw >= half_o) ? half_o - CNT_W'(1) : hold_raw;
  end

  // start hold: divider/16 halved until below the selected limit
  always_comb begin
    lim = fdr_i[5] ? DIV_W'(9) : DIV_W'(16);
    q   = div_i >> 4;
    for (int i = 0; i < DIV_W; i++) begin
      if (q >= lim) q = q >> 1;
    end
    shold_o = (q == '0) ? CNT_W'(1) : CNT_W'(q);
    setup_o = CNT_W'(div_i) + shold_o;
  end

  assert_hold_window_R4: assert property (@(posedge clk) disable iff (rst)
    (hold_o >= CNT_W'(1)) && (hold_o < half_o));

  assert_shold_range_R3: assert property (@(posedge clk) disable iff (rst)
    (shold_o >= CNT_W'(1)) && (fdr_i[5] ? (shold_o < CNT_W'(9)) : (shold_o < CNT_W'(16))));
endmodule

// File: rtl/i2c_bt_sync.sv
module i2c_bt_sync #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic rst,
  input  logic d_i,
  output logic q_o
);
  logic [STAGES-1:0] ff;

  always_ff @(posedge clk) begin
    if (rst) begin
      ff <= '0;
    end else begin
      ff[0] <= d_i;
      for (int i = 1; i < STAGES; i++) ff[i] <= ff[i-1];
    end
  end

  assign q_o = ff[STAGES-1];
endmodule

// File: rtl/i2c_bt_seq.sv
module i2c_bt_seq
  import i2c_bt_pkg::*;
#(
  parameter int CNT_W      = 15,
  parameter int STOP_SETUP = 4
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             cmd_valid_i,
  input  logic [1:0]       cmd_op_i,
  input  logic             cmd_bit_i,
  output logic             cmd_ready_o,
  input  logic [CNT_W-1:0] half_i,
  input  logic [CNT_W-1:0] hold_i,
  input  logic [CNT_W-1:0] shold_i,
  input  logic [CNT_W-1:0] setup_i,
  input  logic             scl_high_i,
  output logic             scl_low_o,
  output logic             sda_low_o,
  output logic             done_o
);
  bt_state_e        state;
  bt_op_e           op_q;
  logic             bit_q;
  logic [CNT_W-1:0] cnt;
  logic [CNT_W-1:0] half_q, hold_q, shold_q, setup_q;
  logic [CNT_W-1:0] hi_lim;
  logic             scl_low_q, sda_low_q, done_q;

  always_comb begin
    case (op_q)
      OP_WRITE:  hi_lim = half_q;
      OP_RSTART: hi_lim = setup_q;
      default:   hi_lim = CNT_W'(STOP_SETUP);
    endcase
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      state     <= ST_IDLE;
      op_q      <= OP_START;
      bit_q     <= 1'b0;
      cnt       <= '0;
      half_q    <= '0;
      hold_q    <= '0;
      shold_q   <= '0;
      setup_q   <= '0;
      scl_low_q <= 1'b0;
      sda_low_q <= 1'b0;
      done_q    <= 1'b0;
    end else begin
      done_q <= 1'b0;
      case (state)
        ST_IDLE: begin
          if (cmd_valid_i) begin
            op_q    <= bt_op_e'(cmd_op_i);
            bit_q   <= cmd_bit_i;
            half_q  <= half_i;
            hold_q  <= hold_i;
            shold_q <= shold_i;
            setup_q <= setup_i;
            cnt     <= '0;
            if (bt_op_e'(cmd_op_i) == OP_START) begin
              sda_low_q <= 1'b1;
              state     <= ST_SHOLD;
            end else begin
              state <= ST_LOW;
            end
          end
        end
        ST_SHOLD: begin
          if (cnt == shold_q - CNT_W'(1)) begin
            scl_low_q <= 1'b1;
            done_q    <= 1'b1;
            state     <= ST_IDLE;
          end else begin
            cnt <= cnt + CNT_W'(1);
          end
        end
        ST_LOW: begin
          if (cnt == hold_q - CNT_W'(1)) begin
            case (op_q)
              OP_WRITE:  sda_low_q <= ~bit_q;
              OP_RSTART: sda_low_q <= 1'b0;
              OP_STOP:   sda_low_q <= 1'b1;
              default:   sda_low_q <= sda_low_q;
            endcase
          end
          if (cnt == half_q - CNT_W'(1)) begin
            scl_low_q <= 1'b0;
            state     <= ST_RISE;
          end else begin
            cnt <= cnt + CNT_W'(1);
          end
        end
        ST_RISE: begin
          if (scl_high_i) begin
            cnt   <= '0;
            state <= ST_HIGH;
          end
        end
        ST_HIGH: begin
          if (cnt == hi_lim - CNT_W'(1)) begin
            cnt <= '0;
            case (op_q)
              OP_WRITE: begin
                scl_low_q <= 1'b1;
                done_q    <= 1'b1;
                state     <= ST_IDLE;
              end
              OP_RSTART: begin
                sda_low_q <= 1'b1;
                state     <= ST_SHOLD;
              end
              default: begin
                sda_low_q <= 1'b0;
                done_q    <= 1'b1;
                state     <= ST_IDLE;
              end
            endcase
          end else begin
            cnt <= cnt + CNT_W'(1);
          end
        end
        default: state <= ST_IDLE;
      endcase
    end
  end

  assign cmd_ready_o = (state == ST_IDLE);
  assign scl_low_o   = scl_low_q;
  assign sda_low_o   = sda_low_q;
  assign done_o      = done_q;

  assert_reset_idle_R1: assert property (@(posedge clk)
    $past(rst) |-> (!scl_low_o && !sda_low_o && !done_o && cmd_ready_o));

  assert_done_pulse_R9: assert property (@(posedge clk) disable iff (rst)
    done_o |=> !done_o);

  assert_high_released_R6: assert property (@(posedge clk) disable iff (rst)
    (state == ST_HIGH) |-> !scl_low_o);

  assert_wait_line_R6: assert property (@(posedge clk) disable iff (rst)
    ((state == ST_RISE) && !scl_high_i) |=> (state == ST_RISE));

  assert_stop_edge_R8: assert property (@(posedge clk) disable iff (rst)
    (!$past(rst) && $fell(sda_low_o) && !scl_low_o) |-> done_o);

  assert_bus_free_R8: assert property (@(posedge clk) disable iff (rst)
    (done_o && !scl_low_o) |-> !sda_low_o);
endmodule

// File: rtl/i2c_bit_timer.sv
module i2c_bit_timer #(
  parameter int DIV_W       = 12,
  parameter int SYNC_STAGES = 2,
  parameter int STOP_SETUP  = 4
) (
  input  logic             clk,
  input  logic             rst,
  input  logic [DIV_W-1:0] div_i,
  input  logic [5:0]       fdr_i,
  input  logic             cmd_valid_i,
  input  logic [1:0]       cmd_op_i,
  input  logic             cmd_bit_i,
  output logic             cmd_ready_o,
  input  logic             scl_i,
  output logic             scl_low_o,
  output logic             sda_low_o,
  output logic             done_o
);
  localparam int CNT_W = (DIV_W + 1 > 15) ? DIV_W + 1 : 15;

  logic [CNT_W-1:0] half_w, hold_w, shold_w, setup_w;
  logic             scl_high_w;

  i2c_bt_timing #(.DIV_W(DIV_W), .CNT_W(CNT_W)) u_timing (
    .clk     (clk),
    .rst     (rst),
    .div_i   (div_i),
    .fdr_i   (fdr_i),
    .half_o  (half_w),
    .hold_o  (hold_w),
    .shold_o (shold_w),
    .setup_o (setup_w)
  );

  i2c_bt_sync #(.STAGES(SYNC_STAGES)) u_sync (
    .clk (clk),
    .rst (rst),
    .d_i (scl_i),
    .q_o (scl_high_w)
  );

  i2c_bt_seq #(.CNT_W(CNT_W), .STOP_SETUP(STOP_SETUP)) u_seq (
    .clk         (clk),
    .rst         (rst),
    .cmd_valid_i (cmd_valid_i),
    .cmd_op_i    (cmd_op_i),
    .cmd_bit_i   (cmd_bit_i),
    .cmd_ready_o (cmd_ready_o),
    .half_i      (half_w),
    .hold_i      (hold_w),
    .shold_i     (shold_w),
    .setup_i     (setup_w),
    .scl_high_i  (scl_high_w),
    .scl_low_o   (scl_low_o),
    .sda_low_o   (sda_low_o),
    .done_o      (done_o)
  );
endmodule

// File: tb/test_i2c_bit_timer.sv
module test_i2c_bit_timer;
  localparam int SYNC = 2;
  localparam int NV   = 8;
  // {divider, code, stretch, expected data hold, expected start hold}
  localparam logic [44:0] VECS [NV] = '{
    {12'd256,  6'b100000, 8'd0, 14'd24,   5'd8},
    {12'd1024, 6'b000000, 8'd3, 14'd56,   5'd8},
    {12'd2048, 6'b000110, 8'd0, 14'd136,  5'd8},
    {12'd600,  6'b110010, 8'd7, 14'd299,  5'd4},
    {12'd300,  6'b000001, 8'd0, 14'd56,   5'd9},
    {12'd40,   6'b101100, 8'd1, 14'd19,   5'd2},
    {12'd4095, 6'b011110, 8'd0, 14'd2046, 5'd15},
    {12'd8,    6'b100000, 8'd2, 14'd3,    5'd1}
  };

  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic [11:0] div = 12'd256;
  logic [5:0]  fdr = 6'd0;
  logic        cmd_valid = 1'b0;
  logic [1:0]  cmd_op = 2'd0;
  logic        cmd_bit = 1'b0;
  logic        ready, scl_low, sda_low, done;
  logic [7:0]  stretch_len = 8'd0;
  logic [7:0]  ext_cnt = 8'd0;
  logic        scl_line;
  int          checks = 0;
  int          errors = 0;

  always #2 clk = ~clk;

  // pull-up plus a slave holding SCL low for stretch_len cycles after release
  always_ff @(posedge clk) begin
    if (scl_low) ext_cnt <= stretch_len;
    else if (ext_cnt != 8'd0) ext_cnt <= ext_cnt - 8'd1;
  end
  assign scl_line = !scl_low && (ext_cnt == 8'd0);

  i2c_bit_timer #(.DIV_W(12), .SYNC_STAGES(SYNC), .STOP_SETUP(4)) i_i2c_bit_timer (
    .clk(clk), .rst(rst), .div_i(div), .fdr_i(fdr),
    .cmd_valid_i(cmd_valid), .cmd_op_i(cmd_op), .cmd_bit_i(cmd_bit),
    .cmd_ready_o(ready), .scl_i(scl_line),
    .scl_low_o(scl_low), .sda_low_o(sda_low), .done_o(done)
  );

  task automatic summary();
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
  endtask

  task automatic chk(input string tag, input int act, input int exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s: actual %0d expected %0d", tag, act, exp);
    end
  endtask

  task automatic do_cmd(input logic [1:0] op, input logic b, input bit poke,
                        output int t_sda1, output int t_sda2, output int t_up,
                        output int t_dn, output int t_done, output int rdy_busy);
    logic ps, pc;
    int s;
    t_sda1 = -1; t_sda2 = -1; t_up = -1; t_dn = -1; t_done = -1; rdy_busy = 0;
    ps = sda_low; pc = scl_low;
    cmd_op = op; cmd_bit = b; cmd_valid = 1'b1;
    @(posedge clk);
    @(negedge clk);
    cmd_valid = 1'b0;
    s = 0;
    while (1) begin
      if (sda_low != ps) begin
        if (t_sda1 < 0) t_sda1 = s; else if (t_sda2 < 0) t_sda2 = s;
        ps = sda_low;
      end
      if (scl_low != pc) begin
        if (!scl_low && t_up < 0) t_up = s;
        if (scl_low && t_dn < 0) t_dn = s;
        pc = scl_low;
      end
      if (done) begin t_done = s; break; end
      if (ready) rdy_busy++;
      if (poke) begin cmd_valid = (s >= 2 && s < 6); cmd_op = 2'd3; end
      if (s > 20000) begin t_done = -2; break; end
      @(negedge clk);
      s++;
    end
    cmd_valid = 1'b0;
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    errors++;
    $display("FAIL watchdog: actual timeout expected completion");
    summary();
    $finish;
  end

  initial begin
    int a1, a2, up, dn, dt, rb, busy;
    int h, d, b, l, p, dv;
    repeat (3) @(negedge clk);
    // R1 reset state
    chk("R1 scl_low after reset", scl_low, 0);
    chk("R1 sda_low after reset", sda_low, 0);
    chk("R1 done after reset", done, 0);
    chk("R1 ready after reset", ready, 1);
    rst = 1'b0;
    @(negedge clk);
    chk("R1 idle bus released", scl_low | sda_low, 0);

    for (int v = 0; v < NV; v++) begin
      dv = int'(VECS[v][44:33]);
      div = VECS[v][44:33];
      fdr = VECS[v][32:27];
      stretch_len = VECS[v][26:19];
      l = int'(VECS[v][26:19]);
      d = int'(VECS[v][18:5]);
      b = int'(VECS[v][4:0]);
      h = (dv / 2 < 2) ? 2 : dv / 2;
      p = h + SYNC + 1 + l;
      busy = 0;

      do_cmd(2'd0, 1'b0, 1'b0, a1, a2, up, dn, dt, rb); busy += rb;
      chk("R2 start sda falls", a1, 0);
      chk("R3 start hold before scl low", dn, b);
      chk("R2 start done", dt, b);

      do_cmd(2'd2, 1'b1, (v == 1), a1, a2, up, dn, dt, rb); busy += rb;
      chk("R4 write1 data hold", a1, d);
      chk("R5 write1 scl release", up, h);
      chk("R6 write1 scl low again", dn, p + h);
      chk("R6 write1 done", dt, p + h);
      chk("R9 no extra sda change while busy", a2, -1);

      do_cmd(2'd2, 1'b0, 1'b0, a1, a2, up, dn, dt, rb); busy += rb;
      chk("R5 write0 sda low at hold", a1, d);
      chk("R5 write0 sda driven", sda_low, 1);
      chk("R6 write0 done", dt, p + h);

      do_cmd(2'd1, 1'b0, 1'b0, a1, a2, up, dn, dt, rb); busy += rb;
      chk("R7 rstart sda release", a1, d);
      chk("R7 rstart scl release", up, h);
      chk("R7 rstart sda fall", a2, p + dv + b);
      chk("R7 rstart scl low", dn, p + dv + b + b);
      chk("R7 rstart done", dt, p + dv + b + b);

      do_cmd(2'd2, 1'b1, 1'b0, a1, a2, up, dn, dt, rb); busy += rb;
      chk("R5 write1 after rstart sda", a1, d);

      do_cmd(2'd3, 1'b0, 1'b0, a1, a2, up, dn, dt, rb); busy += rb;
      chk("R8 stop sda low", a1, d);
      chk("R8 stop scl release", up, h);
      chk("R8 stop sda release", a2, p + 4);
      chk("R8 stop done", dt, p + 4);
      chk("R8 stop scl stays released", dn, -1);
      chk("R9 ready low while busy", busy, 0);
      @(negedge clk);
      chk("R9 done one cycle", done, 0);
      chk("R8 bus free after stop", scl_low | sda_low, 0);
    end

    // R10 reset in the middle of a write
    do_cmd(2'd0, 1'b0, 1'b0, a1, a2, up, dn, dt, rb);
    cmd_op = 2'd2; cmd_bit = 1'b1; cmd_valid = 1'b1;
    @(posedge clk);
    @(negedge clk);
    cmd_valid = 1'b0;
    repeat (2) @(negedge clk);
    chk("R10 busy before reset", ready, 0);
    rst = 1'b1;
    @(posedge clk);
    @(negedge clk);
    rst = 1'b0;
    chk("R10 scl released", scl_low, 0);
    chk("R10 sda released", sda_low, 0);
    chk("R10 ready", ready, 1);
    repeat (10) @(negedge clk);
    chk("R10 stays idle", scl_low | sda_low | done, 0);

    summary();
    $finish;
  end
endmodule